// File: doc/BRIEF.md
# Debug Stack Record Tracker

This block keeps a hardware shadow of stack activity for an at-speed debug monitor. It watches four single-cycle strobes from the core: a data push (or stack-pointer increment), a data pop (or stack-pointer decrement), a subroutine call and a subroutine return. It keeps a 32-bit shift register whose bits record what kind of entry each stack step was. A data push records one 0 bit. A call records two 1 bits, which lets return frames be told apart from data entries.

Alongside the record the block keeps a fill count from 0 to 32. It also has three sticky flags: losing bits off the top of a full record, removing more bits than the record holds, and several strobes arriving in one cycle. The debug side reads the record, the count and the flags while the core keeps running. A one-cycle clear pulse resets the flags. Reset empties the record.

Top module: `stk_record_top`

## Requirements
- R1: While `rst` is high at a clock edge, the record, the fill count and all three flags become zero.
- R2: A lone push strobe shifts the record left by one, places 0 in bit 0 and raises the fill count by one.
- R3: A lone call strobe shifts the record left by two, places 1 in bits 1 and 0 and raises the fill count by two.
- R4: A lone pop strobe shifts the record right by one, places 0 in bit 31 and lowers a nonzero fill count by one.
- R5: A lone return strobe shifts the record right by two, places 0 in bits 31 and 30 and lowers a fill count of at least two by two.
- R6: A push at fill 32, or a call at fill 31 or 32, sets `ovf_flag` and leaves the fill count at 32. The record still shifts.
- R7: A pop at fill 0, or a return at fill 0 or 1, sets `udf_flag` and leaves the fill count at 0. The record still shifts.
- R8: When two or more strobes are high in one cycle, `collide_flag` is set and the record and fill count keep their values.
- R9: The three flags are sticky. Each stays set until a cycle with `dbg_clr` high clears it. If the same cycle also sets that flag, the flag stays set. `dbg_clr` does not change the record or the fill count.
- R10: All outputs change only at the clock edge after the strobe that causes the change. A cycle with no strobe and no clear leaves every output unchanged.
- R11: Record bits at or above position `rec_fill` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_push | input | 1 | Data push or stack-pointer increment strobe |
| ev_pop | input | 1 | Data pop or stack-pointer decrement strobe |
| ev_call | input | 1 | Subroutine call strobe |
| ev_ret | input | 1 | Subroutine return strobe |
| dbg_clr | input | 1 | Clear pulse for the sticky flags |
| rec_bits | output | 32 | Record contents; bit 0 is the newest entry |
| rec_fill | output | 6 | Number of valid record bits, 0 to 32 |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| collide_flag | output | 1 | Sticky flag for simultaneous strobes |

## Verification
Each strobe is registered once, so a wrong shift direction, wrong fill bits or a wrong fill step shows on `rec_bits` or `rec_fill` at the first edge after the strobe. A count that drifts from the record contents breaks the rule that bits above the fill level are zero. This is caught the cycle it happens, and it also shows later as a flag that is set too early or too late at the 0 and 32 boundaries. A flag that clears without `dbg_clr`, or that ignores it, differs from the expected value from the next edge until the next clear. The boundary sequences drive the record to exactly full and exactly empty, with both strobe sizes, so an off-by-one at either end changes the flag on that edge.

// File: rtl/stk_rec_pkg.sv
package stk_rec_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;

    typedef struct packed {
        logic ovf;
        logic udf;
        logic err;
    } stk_flags_s;

    localparam int unsigned NUM_FLAGS = $bits(stk_flags_s);

    function automatic int unsigned fill_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic logic multi_hot(input logic [3:0] v);
        return |(v & (v - 4'd1));
    endfunction

endpackage

// File: rtl/stk_evt_decode.sv
module stk_evt_decode
    import stk_rec_pkg::*;
(
    input  logic    ev_push,
    input  logic    ev_pop,
    input  logic    ev_call,
    input  logic    ev_ret,
    output stk_op_e op,
    output logic    collide
);

    logic [3:0] strobes;

    always_comb begin
        strobes = {ev_ret, ev_call, ev_pop, ev_push};
        collide = multi_hot(strobes);
        op      = OP_IDLE;
        if (!collide) begin
            if (ev_push)      op = OP_PUSH;
            else if (ev_pop)  op = OP_POP;
            else if (ev_call) op = OP_CALL;
            else if (ev_ret)  op = OP_RET;
        end
    end

endmodule

// File: rtl/stk_rec_shift.sv
module stk_rec_shift
    import stk_rec_pkg::*;
#(
    parameter int unsigned REC_W   = 32,
    parameter int unsigned FRAME_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [REC_W-1:0] rec_q
);

    logic [REC_W-1:0] rec_d;

    always_comb begin
        unique case (op)
            OP_PUSH: rec_d = {rec_q[REC_W-2:0], 1'b0};
            OP_CALL: rec_d = {rec_q[REC_W-1-FRAME_W:0], {FRAME_W{1'b1}}};
            OP_POP:  rec_d = {1'b0, rec_q[REC_W-1:1]};
            OP_RET:  rec_d = {{FRAME_W{1'b0}}, rec_q[REC_W-1:FRAME_W]};
            default: rec_d = rec_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

endmodule

// File: rtl/stk_fill_track.sv
module stk_fill_track
    import stk_rec_pkg::*;
#(
    parameter int unsigned REC_W   = 32,
    parameter int unsigned FRAME_W = 2,
    parameter int unsigned CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [CNT_W-1:0] fill_q,
    output logic             ovf_set,
    output logic             udf_set
);

    localparam logic [CNT_W-1:0] FULL     = CNT_W'(REC_W);
    localparam logic [CNT_W-1:0] FRAME    = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CALL_LIM = CNT_W'(REC_W - FRAME_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] fill_d;

    always_comb begin
        fill_d  = fill_q;
        ovf_set = 1'b0;
        udf_set = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (fill_q == FULL) ovf_set = 1'b1;
                else                fill_d  = fill_q + ONE;
            end
            OP_CALL: begin
                if (fill_q > CALL_LIM) begin
                    ovf_set = 1'b1;
                    fill_d  = FULL;
                end else begin
                    fill_d  = fill_q + FRAME;
                end
            end
            OP_POP: begin
                if (fill_q == '0) udf_set = 1'b1;
                else              fill_d  = fill_q - ONE;
            end
            OP_RET: begin
                if (fill_q < FRAME) begin
                    udf_set = 1'b1;
                    fill_d  = '0;
                end else begin
                    fill_d  = fill_q - FRAME;
                end
            end
            default: fill_d = fill_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill_d;
    end

endmodule

// File: rtl/stk_sticky_bank.sv
module stk_sticky_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] hold_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= set[i] | (q & ~clr);
        end
        assign hold_q[i] = q;
    end

endmodule

// File: rtl/stk_record_top.sv
module stk_record_top
    import stk_rec_pkg::*;
#(
    parameter int unsigned REC_W   = 32,
    parameter int unsigned FRAME_W = 2,
    localparam int unsigned CNT_W  = fill_width(REC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_push,
    input  logic             ev_pop,
    input  logic             ev_call,
    input  logic             ev_ret,
    input  logic             dbg_clr,
    output logic [REC_W-1:0] rec_bits,
    output logic [CNT_W-1:0] rec_fill,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             collide_flag
);

    stk_op_e    op;
    logic       collide;
    logic       ovf_set;
    logic       udf_set;
    stk_flags_s set_s;
    stk_flags_s hold_s;

    stk_evt_decode i_decode (
        .ev_push (ev_push),
        .ev_pop  (ev_pop),
        .ev_call (ev_call),
        .ev_ret  (ev_ret),
        .op      (op),
        .collide (collide)
    );

    stk_rec_shift #(
        .REC_W   (REC_W),
        .FRAME_W (FRAME_W)
    ) i_shift (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .rec_q (rec_bits)
    );

    stk_fill_track #(
        .REC_W   (REC_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) i_fill (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .fill_q  (rec_fill),
        .ovf_set (ovf_set),
        .udf_set (udf_set)
    );

    always_comb begin
        set_s.ovf = ovf_set;
        set_s.udf = udf_set;
        set_s.err = collide;
    end

    stk_sticky_bank #(
        .N (NUM_FLAGS)
    ) i_flags (
        .clk    (clk),
        .rst    (rst),
        .clr    (dbg_clr),
        .set    (set_s),
        .hold_q (hold_s)
    );

    assign ovf_flag     = hold_s.ovf;
    assign udf_flag     = hold_s.udf;
    assign collide_flag = hold_s.err;

endmodule

// File: rtl/stk_record_chk.sv
module stk_record_chk #(
    parameter int unsigned REC_W   = 32,
    parameter int unsigned FRAME_W = 2,
    parameter int unsigned CNT_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_push,
    input logic             ev_pop,
    input logic             ev_call,
    input logic             ev_ret,
    input logic             dbg_clr,
    input logic [REC_W-1:0] rec_bits,
    input logic [CNT_W-1:0] rec_fill,
    input logic             ovf_flag,
    input logic             udf_flag,
    input logic             collide_flag
);

    logic [3:0] strb;
    logic       single;
    assign strb   = {ev_ret, ev_call, ev_pop, ev_push};
    assign single = ($countones(strb) == 1);

    a_r2_push_fill: assert property (@(posedge clk) disable iff (rst)
        (single && ev_push && rec_fill < CNT_W'(REC_W)) |=> rec_fill == $past(rec_fill) + CNT_W'(1));

    a_r3_call_marks: assert property (@(posedge clk) disable iff (rst)
        (single && ev_call) |=> rec_bits[FRAME_W-1:0] == {FRAME_W{1'b1}});

    a_r4_pop_fill: assert property (@(posedge clk) disable iff (rst)
        (single && ev_pop && rec_fill != '0) |=> rec_fill == $past(rec_fill) - CNT_W'(1));

    a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
        (single && ev_push && rec_fill == CNT_W'(REC_W)) |=> (ovf_flag && rec_fill == CNT_W'(REC_W)));

    a_r7_underflow: assert property (@(posedge clk) disable iff (rst)
        (single && ev_pop && rec_fill == '0) |=> (udf_flag && rec_fill == '0));

    a_r8_collide_hold: assert property (@(posedge clk) disable iff (rst)
        ($countones(strb) > 1) |=> (collide_flag && $stable(rec_bits) && $stable(rec_fill)));

    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !dbg_clr) |=> ovf_flag);

    a_r9_sticky_udf: assert property (@(posedge clk) disable iff (rst)
        (udf_flag && !dbg_clr) |=> udf_flag);

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (strb == 4'd0 && !dbg_clr) |=> ($stable(rec_bits) && $stable(rec_fill)
                                        && $stable({ovf_flag, udf_flag, collide_flag})));

    a_r11_clean_top: assert property (@(posedge clk) disable iff (rst)
        (rec_fill <= CNT_W'(REC_W)) && ((rec_bits >> rec_fill) == '0));

endmodule

bind stk_record_top stk_record_chk #(
    .REC_W   (REC_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_push      (ev_push),
    .ev_pop       (ev_pop),
    .ev_call      (ev_call),
    .ev_ret       (ev_ret),
    .dbg_clr      (dbg_clr),
    .rec_bits     (rec_bits),
    .rec_fill     (rec_fill),
    .ovf_flag     (ovf_flag),
    .udf_flag     (udf_flag),
    .collide_flag (collide_flag)
);

// File: tb/test_stk_record_top.sv
`timescale 1ns/1ps
module test_stk_record_top;

    typedef struct {
        logic [31:0] bits;
        int          fill;
        logic        ovf;
        logic        udf;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_push = 1'b0, ev_pop = 1'b0, ev_call = 1'b0, ev_ret = 1'b0, dbg_clr = 1'b0;
    logic [31:0] rec_bits;
    logic [5:0]  rec_fill;
    logic        ovf_flag, udf_flag, collide_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    exp_t        sb[$];
    logic [31:0] m_bits = '0;
    int          m_fill = 0;
    logic        m_ovf = 1'b0, m_udf = 1'b0, m_err = 1'b0;

    always #4 clk = ~clk;

    stk_record_top i_stk_record_top (
        .clk          (clk),
        .rst          (rst),
        .ev_push      (ev_push),
        .ev_pop       (ev_pop),
        .ev_call      (ev_call),
        .ev_ret       (ev_ret),
        .dbg_clr      (dbg_clr),
        .rec_bits     (rec_bits),
        .rec_fill     (rec_fill),
        .ovf_flag     (ovf_flag),
        .udf_flag     (udf_flag),
        .collide_flag (collide_flag)
    );

    // Driver: applies one cycle of stimulus and queues the expected outcome
    task automatic step(input logic p, input logic po, input logic c, input logic r,
                        input logic cl, input logic rs, input string tag);
        exp_t e;
        logic so, su, se;
        int   n;
        @(negedge clk);
        rst = rs; ev_push = p; ev_pop = po; ev_call = c; ev_ret = r; dbg_clr = cl;
        so = 1'b0; su = 1'b0; se = 1'b0;
        if (rs) begin
            m_bits = '0; m_fill = 0; m_ovf = 1'b0; m_udf = 1'b0; m_err = 1'b0;
        end else begin
            n = int'(p) + int'(po) + int'(c) + int'(r);
            if (n > 1) begin
                se = 1'b1;
            end else if (p) begin
                m_bits = {m_bits[30:0], 1'b0};
                if (m_fill == 32) so = 1'b1; else m_fill++;
            end else if (c) begin
                m_bits = {m_bits[29:0], 2'b11};
                if (m_fill > 30) begin so = 1'b1; m_fill = 32; end else m_fill += 2;
            end else if (po) begin
                m_bits = {1'b0, m_bits[31:1]};
                if (m_fill == 0) su = 1'b1; else m_fill--;
            end else if (r) begin
                m_bits = {2'b00, m_bits[31:2]};
                if (m_fill < 2) begin su = 1'b1; m_fill = 0; end else m_fill -= 2;
            end
            m_ovf = so | (m_ovf & ~cl);
            m_udf = su | (m_udf & ~cl);
            m_err = se | (m_err & ~cl);
        end
        e.bits = m_bits; e.fill = m_fill; e.ovf = m_ovf; e.udf = m_udf; e.err = m_err; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares one queued expectation shortly after each edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (rec_bits !== e.bits || int'(rec_fill) != e.fill || ovf_flag !== e.ovf
                || udf_flag !== e.udf || collide_flag !== e.err) begin
                n_fail++;
                $display("FAIL %s: got bits=%h fill=%0d ovf=%b udf=%b err=%b, want bits=%h fill=%0d ovf=%b udf=%b err=%b",
                         e.tag, rec_bits, rec_fill, ovf_flag, udf_flag, collide_flag,
                         e.bits, e.fill, e.ovf, e.udf, e.err);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no end of run, want end before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(0, 0, 0, 0, 0, 1, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        // R2 pushes, R3 call, R4 pop, R5 return
        repeat (3) step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, "R5");
        repeat (2) step(0, 0, 0, 0, 0, 0, "R10");
        // R8 collisions
        step(1, 0, 1, 0, 0, 0, "R8");
        step(0, 1, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R9");
        // R7 underflow by pop and by return
        repeat (5) step(0, 1, 0, 0, 0, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R9");
        // R6 overflow by push and by call
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(0, 1, 0, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(1, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 0, "R7");
        // R1: reset in mid-run
        step(0, 0, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 1, "R1");
        // R10 and R11: long mixed sequence
        for (int i = 0; i < 600; i++) begin
            int unsigned k = $urandom_range(0, 15);
            logic cl = ($urandom_range(0, 19) == 0);
            step(k < 5, (k >= 5 && k < 9) || k == 15, k >= 9 && k < 12, k >= 12, cl, 0, "R10");
        end
        step(0, 0, 0, 0, 0, 0, "R10");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule